// File: doc/BRIEF.md
# Pending Exception Capture Register

This block holds one outstanding CPU exception and controls when the program counter is updated around it. An exception request records a type code, an effective address and a return PC. The return PC is moved back one instruction word when the faulting instruction sits in a delay slot. A debugger can tell the block to discard a request, in which case any record is dropped instead. A clear strobe drops the record, but a pending reset exception cannot be dropped this way.

The core also offers PC updates to the block as a candidate PC and next-PC. While the core is stalled with an exception outstanding, the candidate is parked in holding registers and the live PC stays put. When the core resumes, a parked value is copied into the live PC. If an exception is still outstanding at that point, a one-cycle dispatch pulse is raised. Capturing an exception costs no extra cycles: the record is visible on the cycle after the request.

Top module: `exc_pending_reg`

## Requirements
- R1: On a synchronous active-high reset, every output reads zero: pending flag, type, address, saved PC, PC, next PC and dispatch.
- R2: A request with the debug-ignore input low makes the pending flag high on the next cycle. The same cycle shows the request's type code and effective address, with no added wait cycles.
- R3: The captured saved PC equals the current PC minus 4 when the delay-slot input is high, and equals the current PC otherwise.
- R4: A request with debug-ignore high zeroes the pending flag, type, address and saved PC on the next cycle, whatever was held before, including a reset exception.
- R5: A clear strobe zeroes the pending flag, type, address and saved PC, unless the held type equals RESET_TYPE (default code 1); then the record is kept.
- R6: When a non-ignored request and a clear arrive in the same cycle, the request is captured.
- R7: A PC update offered while stalled and with an exception pending is parked; the PC and next-PC outputs do not change.
- R8: A PC update offered while not stalled, or while stalled with nothing pending, appears on the PC and next-PC outputs on the next cycle.
- R9: A resume with a parked update loads the PC and next-PC outputs from it on the next cycle and empties the parking. A later resume leaves the PC unchanged.
- R10: The dispatch output pulses high for one cycle, on the cycle after a resume during which an exception was pending. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Exception request strobe |
| req_type_i | input | TYPE_W | Exception type code |
| req_ea_i | input | PC_W | Effective address of the fault |
| cur_pc_i | input | PC_W | PC of the current instruction |
| in_dslot_i | input | 1 | Current instruction is in a delay slot |
| dbg_ignore_i | input | 1 | Debugger discards this request |
| clr_i | input | 1 | Clear the pending record |
| stall_i | input | 1 | Core is stalled |
| upd_i | input | 1 | Offer a PC update |
| cand_pc_i | input | PC_W | Candidate PC |
| cand_npc_i | input | PC_W | Candidate next PC |
| resume_i | input | 1 | Core resumes from stall |
| pend_valid_o | output | 1 | Exception pending |
| pend_type_o | output | TYPE_W | Pending type code |
| pend_ea_o | output | PC_W | Pending effective address |
| pend_saved_o | output | PC_W | Saved return PC |
| pc_o | output | PC_W | Live PC |
| npc_o | output | PC_W | Live next PC |
| dispatch_o | output | 1 | One-cycle pulse: dispatch pending exception |

## Verification
Two events can land in the same cycle: a request and a clear, and a stalled PC update while a request is still being captured. The bench drives a request together with a clear and expects the new record to win. It also sweeps every type code through capture followed by clear, and expects only the reset code to survive. It judges a parked update by the PC outputs staying frozen until a resume, and by the dispatch pulse appearing on the same cycle as the restored PC.

// File: rtl/exc_pending_reg.sv
module exc_pending_reg #(
  parameter int PC_W       = 32,
  parameter int TYPE_W     = 4,
  parameter int RESET_TYPE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic [TYPE_W-1:0] req_type_i,
  input  logic [PC_W-1:0]   req_ea_i,
  input  logic [PC_W-1:0]   cur_pc_i,
  input  logic              in_dslot_i,
  input  logic              dbg_ignore_i,
  input  logic              clr_i,
  input  logic              stall_i,
  input  logic              upd_i,
  input  logic [PC_W-1:0]   cand_pc_i,
  input  logic [PC_W-1:0]   cand_npc_i,
  input  logic              resume_i,
  output logic              pend_valid_o,
  output logic [TYPE_W-1:0] pend_type_o,
  output logic [PC_W-1:0]   pend_ea_o,
  output logic [PC_W-1:0]   pend_saved_o,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   npc_o,
  output logic              dispatch_o
);

  localparam logic [TYPE_W-1:0] RST_CODE = TYPE_W'(RESET_TYPE);
  localparam logic [PC_W-1:0]   WORD     = PC_W'(4);

  logic            hold_q;
  logic [PC_W-1:0] hold_pc_q, hold_npc_q;

  wire capture  = req_i & ~dbg_ignore_i;
  wire discard  = req_i & dbg_ignore_i;
  wire locked   = pend_valid_o && (pend_type_o == RST_CODE);
  wire drop     = discard | (clr_i & ~locked);
  wire defer    = upd_i & stall_i & pend_valid_o;
  wire restore  = resume_i & hold_q;
  wire [PC_W-1:0] saved_d = in_dslot_i ? cur_pc_i - WORD : cur_pc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_valid_o <= 1'b0;
      pend_type_o  <= '0;
      pend_ea_o    <= '0;
      pend_saved_o <= '0;
    end else if (capture) begin
      pend_valid_o <= 1'b1;
      pend_type_o  <= req_type_i;
      pend_ea_o    <= req_ea_i;
      pend_saved_o <= saved_d;
    end else if (drop) begin
      pend_valid_o <= 1'b0;
      pend_type_o  <= '0;
      pend_ea_o    <= '0;
      pend_saved_o <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= 1'b0;
      hold_pc_q  <= '0;
      hold_npc_q <= '0;
    end else if (restore) begin
      hold_q     <= 1'b0;
      hold_pc_q  <= '0;
      hold_npc_q <= '0;
    end else if (defer) begin
      hold_q     <= 1'b1;
      hold_pc_q  <= cand_pc_i;
      hold_npc_q <= cand_npc_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_o  <= '0;
      npc_o <= '0;
    end else if (restore) begin
      pc_o  <= hold_pc_q;
      npc_o <= hold_npc_q;
    end else if (upd_i && !defer) begin
      pc_o  <= cand_pc_i;
      npc_o <= cand_npc_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) dispatch_o <= 1'b0;
    else     dispatch_o <= resume_i & pend_valid_o;
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (rst)
    (req_i && !dbg_ignore_i) |=> (pend_valid_o && pend_type_o == $past(req_type_i)
                                  && pend_ea_o == $past(req_ea_i)));

  a_r3_dslot_back: assert property (@(posedge clk) disable iff (rst)
    (req_i && !dbg_ignore_i && in_dslot_i) |=> (pend_saved_o + WORD == $past(cur_pc_i)));

  a_r4_ignore_drops: assert property (@(posedge clk) disable iff (rst)
    (req_i && dbg_ignore_i) |=> !pend_valid_o);

  a_r5_reset_kept: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !req_i && pend_valid_o && pend_type_o == RST_CODE) |=> pend_valid_o);

  a_r7_frozen: assert property (@(posedge clk) disable iff (rst)
    (upd_i && stall_i && pend_valid_o && !resume_i) |=> ($stable(pc_o) && $stable(npc_o)));

  a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
    dispatch_o |-> ($past(resume_i) && $past(pend_valid_o)));

endmodule

// File: tb/exc_pending_reg_tb_top.sv
module exc_pending_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        req_i = 0, in_dslot_i = 0, dbg_ignore_i = 0, clr_i = 0;
  logic        stall_i = 0, upd_i = 0, resume_i = 0;
  logic [3:0]  req_type_i = 0;
  logic [31:0] req_ea_i = 0, cur_pc_i = 0, cand_pc_i = 0, cand_npc_i = 0;
  logic        pend_valid_o, dispatch_o;
  logic [3:0]  pend_type_o;
  logic [31:0] pend_ea_o, pend_saved_o, pc_o, npc_o;

  int errors = 0, checks = 0;

  exc_pending_reg dut_i (
    .clk(clk), .rst(rst), .req_i(req_i), .req_type_i(req_type_i), .req_ea_i(req_ea_i),
    .cur_pc_i(cur_pc_i), .in_dslot_i(in_dslot_i), .dbg_ignore_i(dbg_ignore_i),
    .clr_i(clr_i), .stall_i(stall_i), .upd_i(upd_i), .cand_pc_i(cand_pc_i),
    .cand_npc_i(cand_npc_i), .resume_i(resume_i), .pend_valid_o(pend_valid_o),
    .pend_type_o(pend_type_o), .pend_ea_o(pend_ea_o), .pend_saved_o(pend_saved_o),
    .pc_o(pc_o), .npc_o(npc_o), .dispatch_o(dispatch_o));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    req_i = 0; dbg_ignore_i = 0; clr_i = 0; upd_i = 0; resume_i = 0; in_dslot_i = 0;
  endtask

  task automatic offer(input logic [31:0] p, input logic s);
    upd_i = 1; cand_pc_i = p; cand_npc_i = p + 4; stall_i = s;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pcv, held;
    step(); step();
    rst = 0;
    check("R1 valid", pend_valid_o, 0); check("R1 type", pend_type_o, 0);
    check("R1 ea", pend_ea_o, 0); check("R1 saved", pend_saved_o, 0);
    check("R1 pc", pc_o, 0); check("R1 npc", npc_o, 0); check("R1 dispatch", dispatch_o, 0);

    for (int t = 0; t < 16; t++) begin
      for (int d = 0; d < 2; d++) begin
        pcv = 32'h0000_2000 + 32'(t) * 32'h40 + 32'(d) * 8;
        req_i = 1; req_type_i = 4'(t); req_ea_i = 32'hA000_0000 ^ pcv;
        cur_pc_i = pcv; in_dslot_i = d[0];
        step();
        check("R2 valid", pend_valid_o, 1);
        check("R2 type", pend_type_o, 32'(t));
        check("R2 ea", pend_ea_o, 32'hA000_0000 ^ pcv);
        check("R3 saved", pend_saved_o, d ? pcv - 4 : pcv);
        clr_i = 1; step();
        check("R5 clear", pend_valid_o, (t == 1) ? 1 : 0);
        check("R5 saved", pend_saved_o, (t == 1) ? (d ? pcv - 4 : pcv) : 0);
        if (t == 1) begin
          req_i = 1; dbg_ignore_i = 1; req_type_i = 4'd7; step();
          check("R4 valid", pend_valid_o, 0); check("R4 saved", pend_saved_o, 0);
          check("R4 type", pend_type_o, 0); check("R4 ea", pend_ea_o, 0);
        end
      end
    end

    req_i = 1; req_type_i = 4'd3; req_ea_i = 32'h55; cur_pc_i = 32'h300; clr_i = 1; step();
    check("R6 valid", pend_valid_o, 1); check("R6 type", pend_type_o, 3);
    clr_i = 1; step();
    check("R5 drop", pend_valid_o, 0);

    offer(32'h1000, 0); step();
    check("R8 pc", pc_o, 32'h1000); check("R8 npc", npc_o, 32'h1004);
    offer(32'h1100, 1); step();
    check("R8 stalled pc", pc_o, 32'h1100); check("R8 stalled npc", npc_o, 32'h1104);

    for (int k = 0; k < 4; k++) begin
      held = 32'h8000 + 32'(k) * 32'h100;
      pcv = pc_o;
      req_i = 1; req_type_i = 4'd5; cur_pc_i = 32'h40; step();
      offer(held, 1); step();
      check("R7 pc frozen", pc_o, pcv); check("R7 npc frozen", npc_o, pcv + 4);
      check("R10 idle", dispatch_o, 0);
      offer(held + 32'h10, 1); step();
      check("R7 pc frozen2", pc_o, pcv);
      stall_i = 0; resume_i = 1; step();
      check("R9 pc", pc_o, held + 32'h10); check("R9 npc", npc_o, held + 32'h14);
      check("R10 pulse", dispatch_o, 1);
      step();
      check("R10 one cycle", dispatch_o, 0);
      resume_i = 1; step();
      check("R9 empty", pc_o, held + 32'h10); check("R10 still pending", dispatch_o, 1);
      clr_i = 1; step();
      resume_i = 1; step();
      check("R10 none pending", dispatch_o, 0);
      check("R9 unchanged", pc_o, held + 32'h10);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule